// File: doc/BRIEF.md
# PWM Output Router with Soft Ramp

This block takes three modulator bit streams (channel 1, channel 2 and a subwoofer channel, each with a plus and a minus phase) and drives four power-stage pins from them. A two-bit configuration picks one of three arrangements: stereo full-bridge, stereo half-bridge with a full-bridge subwoofer, or a single channel in parallel full-bridge. The configuration may only be changed while the whole output section is held in global power-down. A write at any other time leaves it as it was.

Each pin also has a soft-start and soft-stop sequencer. When a pin is enabled, it does not switch straight to the modulator stream. It first outputs a locally generated PWM wave whose duty climbs one step at a time from zero up to the half-supply bias point, which is exactly 50 % duty. Only at that point does the pin take the modulator stream. When the pin is disabled, the duty walks back down to zero and the pin then rests low. A ramp that is interrupted turns around from the duty it has reached. A busy flag stays high while any pin has not yet reached its settled state.

Software reaches the block through a two-entry write port. Entry 0 holds the configuration. Entry 1 holds the global power-down bit and four per-pin power-down bits.

Top module: `pwm_route_ramp`

## Requirements
- R1: After reset the global power-down bit is 1, every per-pin power-down bit is 0, the configuration is 00, all four pins are low and `rampBusy` is 0.
- R2: A configuration write (`wrSel`=0, value in `wrData[1:0]`) takes effect only if the global power-down bit is already 1 at the write. Otherwise the write is dropped and the routing does not change.
- R3: A configuration write of 11 is reserved and always dropped; the previous configuration stays.
- R4: Once pins have settled, they carry these streams, where index 0 = channel 1, 1 = channel 2, 2 = sub. Config 00: `pwmOut[0]`=modP[0], `pwmOut[1]`=modN[0], `pwmOut[2]`=modP[1], `pwmOut[3]`=modN[1]. Config 01: modP[0], modP[1], modP[2], modN[2]. Config 10: modP[0], modP[0], modN[0], modN[0].
- R5: An enabled pin ramps its duty from 0 up to the bias value 2^(DUTY_W-1), one count every STEP_DIV clock cycles. While ramping, the pin is high when a free-running DUTY_W-bit counter is below the duty.
- R6: While a pin is ramping, the modulator input has no effect on it and `rampBusy` is 1. The pin follows its routed modulator stream only once the duty equals the bias.
- R7: A disabled pin ramps its duty down at the same rate, then stays low whatever the modulators do. `rampBusy` returns to 0 once every pin is settled.
- R8: Disabling a pin partway through its power-up ramp reverses the ramp from the duty already reached, with no jump.
- R9: A pin is enabled only when the global power-down bit is 0 and its own power-down bit (`wrData[i+1]` of entry 1) is 0. Pins are sequenced independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0: configuration entry, 1: power entry |
| wrData | input | 5 | Write data. Config: bits 1:0. Power: bit 0 global power-down, bits 4:1 per-pin power-down |
| modP | input | 3 | Modulator plus phases (ch1, ch2, sub) |
| modN | input | 3 | Modulator minus phases (ch1, ch2, sub) |
| pwmOut | output | 4 | Power-stage pin drive |
| rampBusy | output | 1 | High while any pin is not settled |

## Verification
The assertions assume that reset is held for at least one clock edge before it is released, so that every `$past` term refers to a defined register value. They also assume that a write strobe lasts a single cycle with stable select and data. The bench drives all inputs on the falling edge and raises `wrEn` for exactly one cycle per write. It changes modulator inputs freely, because the routing and ramp properties depend only on the registered power state and step tick.

// File: rtl/pwm_route_pkg.sv
package pwm_route_pkg;
  localparam int NUM_OUT = 4;
  localparam int NUM_SRC = 3;
  localparam int REG_W   = 5;

  typedef enum logic [1:0] {
    CFG_STEREO_FB = 2'b00,
    CFG_HB_SUB    = 2'b01,
    CFG_MONO_PAR  = 2'b10,
    CFG_RSVD      = 2'b11
  } outCfg_e;

  typedef struct packed {
    logic               stepTick;
    logic [NUM_OUT-1:0] want;
    outCfg_e            cfg;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_route_ctrl.sv
module pwm_route_ctrl
  import pwm_route_pkg::*;
#(
  parameter int STEP_DIV = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [REG_W-1:0] wrData,
  output ctrlStrobe_t      strobe
);
  localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);

  outCfg_e            cfgReg;
  logic               pdnAllReg;
  logic [NUM_OUT-1:0] pdnOutReg;
  logic [DIV_W-1:0]   divCnt;
  logic               cfgWriteOk;

  assign cfgWriteOk = wrEn && !wrSel && pdnAllReg && (wrData[1:0] != 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg    <= CFG_STEREO_FB;
      pdnAllReg <= 1'b1;
      pdnOutReg <= '0;
    end else begin
      if (wrEn && wrSel) begin
        pdnAllReg <= wrData[0];
        pdnOutReg <= wrData[NUM_OUT:1];
      end
      if (cfgWriteOk) cfgReg <= outCfg_e'(wrData[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobe.stepTick = (divCnt == DIV_LAST);
    strobe.cfg      = cfgReg;
    for (int i = 0; i < NUM_OUT; i++) strobe.want[i] = !pdnAllReg && !pdnOutReg[i];
  end

  AST_CFG_GATED: assert property (@(posedge clk) disable iff (rst)
    (cfgReg != $past(cfgReg)) |-> $past(pdnAllReg)); // R2
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cfgReg != CFG_RSVD)); // R3
endmodule

// File: rtl/pwm_route_dp.sv
module pwm_route_dp
  import pwm_route_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] modP,
  input  logic [NUM_SRC-1:0] modN,
  output logic [NUM_OUT-1:0] pinOut,
  output logic               busy
);
  localparam logic [DUTY_W-1:0] BIAS = DUTY_W'(1 << (DUTY_W - 1));

  logic [DUTY_W-1:0]  pwmCnt;
  logic [DUTY_W-1:0]  duty [NUM_OUT];
  logic [NUM_OUT-1:0] routed;
  logic [NUM_OUT-1:0] settled;
  logic [NUM_OUT-1:0] live;

  always_ff @(posedge clk) begin
    if (rst) pwmCnt <= '0;
    else pwmCnt <= pwmCnt + 1'b1;
  end

  always_comb begin
    case (strobe.cfg)
      CFG_HB_SUB:   routed = {modN[2], modP[2], modP[1], modP[0]};
      CFG_MONO_PAR: routed = {modN[0], modN[0], modP[0], modP[0]};
      default:      routed = {modN[1], modP[1], modN[0], modP[0]};
    endcase
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) duty[i] <= '0;
      else if (strobe.stepTick) begin
        if (strobe.want[i] && duty[i] < BIAS) duty[i] <= duty[i] + 1'b1;
        else if (!strobe.want[i] && duty[i] != '0) duty[i] <= duty[i] - 1'b1;
      end
    end

    assign live[i]    = strobe.want[i] && (duty[i] == BIAS);
    assign settled[i] = strobe.want[i] ? (duty[i] == BIAS) : (duty[i] == '0);
    assign pinOut[i]  = live[i] ? routed[i] : (pwmCnt < duty[i]);

    AST_DUTY_BOUND: assert property (@(posedge clk) disable iff (rst)
      (duty[i] <= BIAS)); // R5
    AST_DUTY_RATE: assert property (@(posedge clk) disable iff (rst)
      (duty[i] != $past(duty[i])) |-> $past(strobe.stepTick)); // R5
    AST_UP_DIR: assert property (@(posedge clk) disable iff (rst)
      strobe.want[i] |=> (duty[i] >= $past(duty[i]))); // R8
    AST_DOWN_DIR: assert property (@(posedge clk) disable iff (rst)
      !strobe.want[i] |=> (duty[i] <= $past(duty[i]))); // R7
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
      (!strobe.want[i] && duty[i] == '0) |-> !pinOut[i]); // R7
  end

  assign busy = !(&settled);
endmodule

// File: rtl/pwm_route_ramp.sv
module pwm_route_ramp
  import pwm_route_pkg::*;
#(
  parameter int DUTY_W   = 10,
  parameter int STEP_DIV = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [4:0]   wrData,
  input  logic [2:0]   modP,
  input  logic [2:0]   modN,
  output logic [3:0]   pwmOut,
  output logic         rampBusy
);
  ctrlStrobe_t strobe;

  pwm_route_ctrl #(.STEP_DIV(STEP_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobe(strobe)
  );

  pwm_route_dp #(.DUTY_W(DUTY_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .modP(modP), .modN(modN),
    .pinOut(pwmOut), .busy(rampBusy)
  );
endmodule

// File: tb/pwm_route_ramp_test.sv
module pwm_route_ramp_test;
  localparam int DUTY_W   = 6;
  localparam int STEP_DIV = 64;
  localparam int SETTLE   = 2400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [4:0] wrData = '0;
  logic [2:0] modP = '0;
  logic [2:0] modN = '0;
  logic [3:0] pwmOut;
  logic       rampBusy;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  pwm_route_ramp #(.DUTY_W(DUTY_W), .STEP_DIV(STEP_DIV)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .modP(modP), .modN(modN), .pwmOut(pwmOut), .rampBusy(rampBusy)
  );

  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [4:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPower(input logic pdnAll, input logic [3:0] pdnOut);
    wr(1'b1, {pdnOut, pdnAll});
  endtask

  task automatic countHigh(input int idx, output int cnt);
    cnt = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (pwmOut[idx]) cnt++;
    end
  endtask

  function automatic logic [3:0] expRoute(input logic [1:0] c, input logic [2:0] p, input logic [2:0] n);
    case (c)
      2'b01:   return {n[2], p[2], p[1], p[0]};
      2'b10:   return {n[0], n[0], p[0], p[0]};
      default: return {n[1], p[1], n[0], p[0]};
    endcase
  endfunction

  task automatic checkRoute(input logic [1:0] c, input string tag);
    modP = 3'b101; modN = 3'b010; waitCyc(2);
    chk(pwmOut == expRoute(c, modP, modN), tag, pwmOut, expRoute(c, modP, modN));
    modP = 3'b011; modN = 3'b110; waitCyc(2);
    chk(pwmOut == expRoute(c, modP, modN), tag, pwmOut, expRoute(c, modP, modN));
  endtask

  task automatic changeCfg(input logic [1:0] c);
    setPower(1'b1, 4'b0000); waitCyc(SETTLE);
    wr(1'b0, {3'b000, c});
    setPower(1'b0, 4'b0000); waitCyc(SETTLE);
  endtask

  task automatic t_reset;
    modP = 3'b111; modN = 3'b111; waitCyc(4);
    chk(pwmOut == 4'b0000, "R1 pins low after reset", pwmOut, 0);
    chk(rampBusy == 1'b0, "R1 busy low after reset", rampBusy, 0);
  endtask

  task automatic t_rampUp;
    int c;
    modP = 3'b111; modN = 3'b111;
    setPower(1'b0, 4'b0000);
    countHigh(0, c);
    chk(c <= 3, "R5 early ramp duty small", c, 1);
    chk(rampBusy == 1'b1, "R6 busy during ramp", rampBusy, 1);
    waitCyc(1024 - 64);
    countHigh(0, c);
    chk(c >= 13 && c <= 19, "R5 mid ramp duty", c, 16);
    modP = 3'b000; modN = 3'b000;
    countHigh(0, c);
    chk(c >= 14 && c <= 20, "R6 modulator ignored while ramping", c, 17);
    chk(rampBusy == 1'b1, "R6 busy mid ramp", rampBusy, 1);
    waitCyc(SETTLE);
    chk(rampBusy == 1'b0, "R6 busy clears at bias", rampBusy, 0);
    chk(pwmOut == 4'b0000, "R6 follows modulator low", pwmOut, 0);
    modP = 3'b111; modN = 3'b111; waitCyc(2);
    chk(pwmOut == 4'b1111, "R6 follows modulator high", pwmOut, 15);
  endtask

  task automatic t_route;
    checkRoute(2'b00, "R4 R1 stereo full-bridge default");
    changeCfg(2'b01);
    checkRoute(2'b01, "R4 half-bridge plus sub");
    changeCfg(2'b10);
    checkRoute(2'b10, "R4 mono parallel");
  endtask

  task automatic t_gate;
    wr(1'b0, 5'b00000);
    checkRoute(2'b10, "R2 write while powered up dropped");
  endtask

  task automatic t_rsvd;
    changeCfg(2'b11);
    checkRoute(2'b10, "R3 reserved code dropped");
  endtask

  task automatic t_rampDown;
    int c;
    modP = 3'b111; modN = 3'b111;
    setPower(1'b1, 4'b0000);
    waitCyc(1024 - 64);
    countHigh(0, c);
    chk(c >= 13 && c <= 19, "R7 mid ramp-down duty", c, 16);
    chk(rampBusy == 1'b1, "R7 busy during ramp-down", rampBusy, 1);
    waitCyc(SETTLE);
    chk(pwmOut == 4'b0000, "R7 low after ramp-down", pwmOut, 0);
    chk(rampBusy == 1'b0, "R7 busy clears after ramp-down", rampBusy, 0);
  endtask

  task automatic t_reverse;
    int c;
    modP = 3'b111; modN = 3'b111;
    setPower(1'b0, 4'b0000);
    waitCyc(640);
    setPower(1'b1, 4'b0000);
    countHigh(0, c);
    chk(c >= 6 && c <= 13, "R8 reversal keeps duty", c, 9);
    chk(rampBusy == 1'b1, "R8 busy after reversal", rampBusy, 1);
    waitCyc(900);
    chk(rampBusy == 1'b0, "R8 reversal settles", rampBusy, 0);
    chk(pwmOut == 4'b0000, "R8 low after reversal", pwmOut, 0);
  endtask

  task automatic t_perOut;
    modP = 3'b111; modN = 3'b111;
    setPower(1'b0, 4'b1110);
    waitCyc(SETTLE);
    chk(pwmOut == 4'b0001, "R9 only pin 0 enabled", pwmOut, 1);
    chk(rampBusy == 1'b0, "R9 settled with mixed enables", rampBusy, 0);
    modP = 3'b110; waitCyc(2);
    chk(pwmOut == 4'b0000, "R9 pin 0 follows modulator", pwmOut, 0);
  endtask

  initial begin
    waitCyc(5);
    rst = 1'b0;
    waitCyc(2);
    t_reset();
    t_rampUp();
    t_route();
    t_gate();
    t_rsvd();
    setPower(1'b0, 4'b0000); waitCyc(SETTLE);
    t_rampDown();
    t_reverse();
    t_perOut();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule